// File: doc/BRIEF.md
# Floating-Point Status and Exception Register

This block holds the status and control word that sits beside a processor's floating-point datapath. Software writes it through a load port with a fixed mask of implemented bits. Two fields drive the datapath's configuration directly: a rounding-mode selector and a denormal-flush control bit.

After every arithmetic operation the datapath pulses a completion strobe. With the strobe it reports five raw exception bits: invalid, divide-by-zero, overflow, underflow and inexact. The register replaces its cause field with that report and accumulates the same bits into a sticky flag field. It then compares the new cause bits against the enable field and raises a one-cycle trap request carrying a fixed vector code. Approximate operations, such as a reciprocal square-root estimate, assert an extra input that reports inexact when the datapath saw nothing else.

Top module: `fpstat_reg`

## Requirements
- R1: A load writes `ld_data & 32'h0007FFFF`. Bits 31:19 of `csr_q` always read as zero.
- R2: `round_trunc` is 1 exactly when `csr_q[1:0]` is 2'b01 (round toward zero). Every other code (00, 10, 11) gives 0, which selects round-to-nearest-even.
- R3: `flush_denorm` equals `csr_q[18]`.
- R4: An accepted operation replaces the whole cause field `csr_q[17:12]`. The exception input `op_exc` uses V=bit4, Z=bit3, O=bit2, U=bit1, I=bit0. These land at cause bits 16, 15, 14, 13 and 12, and bit 17 becomes 0.
- R5: An accepted operation ORs the same bits into the flags at `csr_q[6:2]` (V=6, Z=5, O=4, U=3, I=2). An operation never clears a flag.
- R6: One cycle after an accepted operation, `trap_req` pulses high for that cycle only if the new cause bits ANDed with the enable field are nonzero. The enable field is `csr_q[11:7]` with V=11, Z=10, O=9, U=8, I=7, taken as it stood before the operation. While `trap_req` is high, `trap_vec` is 12'h120. At all other times both outputs are 0.
- R7: When `op_approx` is high and `op_exc` is all zero, the operation is treated as reporting inexact only. When `op_exc` is nonzero, `op_approx` has no effect.
- R8: When `ld_en` and `op_done` are high in the same cycle, the load is applied and the operation is ignored. There is no cause or flag update and no trap.
- R9: After reset, `csr_q` is 0, `round_trunc` is 0, `flush_denorm` is 0 and `trap_req` is 0.
- R10: An operation leaves the rounding mode, the enable field and the denormal bit unchanged. A cycle with neither a load nor a strobe leaves `csr_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Software load strobe |
| ld_data | input | 32 | Value to load |
| op_done | input | 1 | Operation completion strobe |
| op_exc | input | 5 | Raw exceptions {V,Z,O,U,I} |
| op_approx | input | 1 | Operation is an approximation |
| csr_q | output | 32 | Current register value |
| round_trunc | output | 1 | 1 selects truncation, 0 selects round-to-nearest-even |
| flush_denorm | output | 1 | Flush denormals to zero |
| trap_req | output | 1 | Exception trap request pulse |
| trap_vec | output | 12 | Trap vector code |

## Verification
Every result is due one clock edge after the stimulus that causes it. A load or an operation changes `csr_q` at the next rising edge. `round_trunc` and `flush_denorm` follow in the same cycle, and the trap pulse appears at that same edge. The driver applies inputs on the falling edge and pushes one expected item per cycle into a queue. The monitor pops that item 1 ns after the following rising edge, so each comparison lands in the cycle where the result is due. Because an item is pushed for every cycle, idle cycles are checked too, which is how the bench confirms that a trap lasts one cycle and that nothing changes without a stimulus.

// File: rtl/fpstat_pkg.sv
package fpstat_pkg;
  localparam int CSR_W     = 32;
  localparam int EXC_W     = 5;
  localparam int RM_LSB    = 0;
  localparam int RM_W      = 2;
  localparam int FLAG_LSB  = 2;
  localparam int EN_LSB    = FLAG_LSB + EXC_W;
  localparam int CAUSE_LSB = EN_LSB + EXC_W;
  localparam int CAUSE_W   = EXC_W + 1;
  localparam int DN_BIT    = CAUSE_LSB + CAUSE_W;
  localparam int VEC_W     = 12;
  localparam int IMPL_W    = DN_BIT + 1;
  localparam logic [CSR_W-1:0] IMPL_MASK = CSR_W'((64'd1 << IMPL_W) - 64'd1);
  localparam logic [RM_W-1:0]  RM_RTZ    = 2'b01;
  localparam logic [EXC_W-1:0] EXC_INEXACT = 5'b00001;
endpackage

// File: rtl/fpstat_exc_merge.sv
module fpstat_exc_merge
  import fpstat_pkg::*;
(
  input  logic [EXC_W-1:0] exc_raw,
  input  logic             approx,
  output logic [EXC_W-1:0] exc_eff
);
  logic none_raised;

  always_comb begin
    none_raised = (exc_raw == '0);
    if (approx && none_raised) exc_eff = EXC_INEXACT;
    else                       exc_eff = exc_raw;
  end
endmodule

// File: rtl/fpstat_ctrl_dec.sv
module fpstat_ctrl_dec
  import fpstat_pkg::*;
(
  input  logic [RM_W-1:0] rm,
  input  logic            dn,
  output logic            round_trunc,
  output logic            flush_denorm
);
  always_comb begin
    round_trunc  = (rm == RM_RTZ);
    flush_denorm = dn;
  end
endmodule

// File: rtl/fpstat_trap.sv
module fpstat_trap
  import fpstat_pkg::*;
#(
  parameter logic [VEC_W-1:0] TRAP_VEC = 12'h120
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_take,
  input  logic [EXC_W-1:0] cause_new,
  input  logic [EXC_W-1:0] enables,
  output logic             trap_req,
  output logic [VEC_W-1:0] trap_vec
);
  logic             req_d;
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    req_d = op_take && ((cause_new & enables) != '0);
    vec_d = req_d ? TRAP_VEC : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_req <= 1'b0;
      trap_vec <= '0;
    end else begin
      trap_req <= req_d;
      trap_vec <= vec_d;
    end
  end
endmodule

// File: rtl/fpstat_reg.sv
module fpstat_reg
  import fpstat_pkg::*;
#(
  parameter logic [VEC_W-1:0] TRAP_VEC  = 12'h120,
  parameter logic [CSR_W-1:0] RESET_VAL = 32'h0000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [CSR_W-1:0] ld_data,
  input  logic             op_done,
  input  logic [EXC_W-1:0] op_exc,
  input  logic             op_approx,
  output logic [CSR_W-1:0] csr_q,
  output logic             round_trunc,
  output logic             flush_denorm,
  output logic             trap_req,
  output logic [VEC_W-1:0] trap_vec
);
  localparam int CAUSE_PAD = CAUSE_W - EXC_W;

  logic [EXC_W-1:0] exc_eff;
  logic [CSR_W-1:0] csr_d;
  logic             csr_en;
  logic             op_take;

  fpstat_exc_merge u_merge (
    .exc_raw (op_exc),
    .approx  (op_approx),
    .exc_eff (exc_eff)
  );

  always_comb begin
    op_take = op_done && !ld_en;
    csr_en  = ld_en || op_done;
    csr_d   = csr_q;
    if (ld_en) begin
      csr_d = ld_data & IMPL_MASK;
    end else if (op_done) begin
      csr_d[CAUSE_LSB +: CAUSE_W] = {{CAUSE_PAD{1'b0}}, exc_eff};
      csr_d[FLAG_LSB +: EXC_W]    = csr_q[FLAG_LSB +: EXC_W] | exc_eff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      csr_q <= RESET_VAL & IMPL_MASK;
    else if (csr_en) csr_q <= csr_d;
  end

  fpstat_trap #(.TRAP_VEC(TRAP_VEC)) u_trap (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_take   (op_take),
    .cause_new (exc_eff),
    .enables   (csr_q[EN_LSB +: EXC_W]),
    .trap_req  (trap_req),
    .trap_vec  (trap_vec)
  );

  fpstat_ctrl_dec u_dec (
    .rm           (csr_q[RM_LSB +: RM_W]),
    .dn           (csr_q[DN_BIT]),
    .round_trunc  (round_trunc),
    .flush_denorm (flush_denorm)
  );
endmodule

// File: rtl/fpstat_reg_chk.sv
module fpstat_reg_chk
  import fpstat_pkg::*;
#(
  parameter logic [VEC_W-1:0] TRAP_VEC = 12'h120
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_en,
  input logic [CSR_W-1:0] ld_data,
  input logic             op_done,
  input logic [CSR_W-1:0] csr_q,
  input logic             round_trunc,
  input logic             flush_denorm,
  input logic             trap_req,
  input logic [VEC_W-1:0] trap_vec
);
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_q & ~IMPL_MASK) == '0);  // R1
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> csr_q == ($past(ld_data) & IMPL_MASK));  // R8
  AST_RTZ_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(csr_q[1:0]) |-> (round_trunc == (csr_q[1:0] == 2'b01)));  // R2
  AST_FLUSH_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    flush_denorm == csr_q[DN_BIT]);  // R3
  AST_CAUSE_TOP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !ld_en) |=> !csr_q[CAUSE_LSB + CAUSE_W - 1]);  // R4
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !ld_en) |=> ((csr_q[FLAG_LSB +: EXC_W] & $past(csr_q[FLAG_LSB +: EXC_W]))
                             == $past(csr_q[FLAG_LSB +: EXC_W])));  // R5
  AST_TRAP_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_done || ld_en) |=> !trap_req);  // R6
  AST_TRAP_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> trap_vec == TRAP_VEC);  // R6
  AST_CTRL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !ld_en) |=> ($stable(csr_q[EN_LSB +: EXC_W]) && $stable(csr_q[1:0])
                             && $stable(csr_q[DN_BIT])));  // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_done && !ld_en) |=> $stable(csr_q));  // R10
endmodule

bind fpstat_reg fpstat_reg_chk #(.TRAP_VEC(TRAP_VEC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ld_en        (ld_en),
  .ld_data      (ld_data),
  .op_done      (op_done),
  .csr_q        (csr_q),
  .round_trunc  (round_trunc),
  .flush_denorm (flush_denorm),
  .trap_req     (trap_req),
  .trap_vec     (trap_vec)
);

// File: tb/test_fpstat_reg.sv
module test_fpstat_reg;
  logic        clk;
  logic        rst_n;
  logic        ld_en;
  logic [31:0] ld_data;
  logic        op_done;
  logic [4:0]  op_exc;
  logic        op_approx;
  logic [31:0] csr_q;
  logic        round_trunc;
  logic        flush_denorm;
  logic        trap_req;
  logic [11:0] trap_vec;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] csr;
    logic        trap;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [31:0] m_csr;

  fpstat_reg i_fpstat_reg (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_data(ld_data),
    .op_done(op_done), .op_exc(op_exc), .op_approx(op_approx),
    .csr_q(csr_q), .round_trunc(round_trunc), .flush_denorm(flush_denorm),
    .trap_req(trap_req), .trap_vec(trap_vec)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected result
  task automatic drive(input logic ld, input logic [31:0] d, input logic op,
                       input logic [4:0] e, input logic ap, input string tag);
    exp_t it;
    logic [4:0] ee;
    logic       tr;
    @(negedge clk);
    ld_en = ld; ld_data = d; op_done = op; op_exc = e; op_approx = ap;
    tr = 1'b0;
    if (ld) begin
      m_csr = d & 32'h0007FFFF;
    end else if (op) begin
      ee = (ap && e == 5'd0) ? 5'b00001 : e;
      tr = ((ee & m_csr[11:7]) != 5'd0);
      m_csr[17:12] = {1'b0, ee};
      m_csr[6:2]   = m_csr[6:2] | ee;
    end
    it.csr = m_csr; it.trap = tr; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compares one expected item per cycle, 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t it;
        logic [11:0] ev;
        it = q.pop_front();
        ev = it.trap ? 12'h120 : 12'h000;
        check(csr_q == it.csr, {it.tag, " csr"}, 64'(csr_q), 64'(it.csr));
        check(round_trunc == (it.csr[1:0] == 2'b01), {it.tag, " round_trunc"},
              64'(round_trunc), 64'(it.csr[1:0] == 2'b01));
        check(flush_denorm == it.csr[18], {it.tag, " flush"},
              64'(flush_denorm), 64'(it.csr[18]));
        check(trap_req == it.trap && trap_vec == ev, {it.tag, " trap"},
              {51'd0, trap_req, trap_vec}, {51'd0, it.trap, ev});
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ld_en = 0; ld_data = 0; op_done = 0; op_exc = 0; op_approx = 0;
    m_csr = 32'h0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(csr_q == 32'h0 && !round_trunc && !flush_denorm && !trap_req,
          "R9 reset", 64'(csr_q), 64'h0);
    rst_n = 1;
    // R1 R3: masked load, rm=11 gives nearest
    drive(1, 32'hFFFF_FFFF, 0, 5'd0, 0, "R1 R3 full load");
    drive(0, 32'h0, 0, 5'd0, 0, "R10 idle");
    // R2 rounding codes
    drive(1, 32'h0000_0001, 0, 5'd0, 0, "R2 rtz code");
    drive(1, 32'h0000_0002, 0, 5'd0, 0, "R2 code 10");
    drive(1, 32'h0004_0000, 0, 5'd0, 0, "R3 flush on");
    drive(1, 32'h0000_0000, 0, 5'd0, 0, "R1 clear");
    // R4 R5 cause replaced, flags sticky, no enables -> no trap
    drive(0, 32'h0, 1, 5'b10100, 0, "R4 R5 R6 op V O");
    drive(0, 32'h0, 1, 5'b00010, 0, "R4 R5 op U");
    drive(0, 32'h0, 1, 5'b00000, 0, "R4 R5 op clean");
    // R7 approximate
    drive(0, 32'h0, 1, 5'b00000, 1, "R7 forced inexact");
    drive(0, 32'h0, 1, 5'b01000, 1, "R7 reported wins");
    // R6 enable V, trap, then pulse ends
    drive(1, 32'h0000_0801, 0, 5'd0, 0, "R6 enable V rtz");
    drive(0, 32'h0, 1, 5'b10000, 0, "R6 trap V R10 ctrl kept");
    drive(0, 32'h0, 0, 5'd0, 0, "R6 pulse ends");
    drive(0, 32'h0, 1, 5'b00001, 0, "R6 not enabled");
    drive(0, 32'h0, 1, 5'b10001, 0, "R6 back to back 1");
    drive(0, 32'h0, 1, 5'b10000, 0, "R6 back to back 2");
    // R8 load wins over op
    drive(1, 32'h0000_0F80, 1, 5'b11111, 0, "R8 load priority");
    drive(0, 32'h0, 0, 5'd0, 0, "R8 no trap after");
    // R7 approximate with enabled inexact
    drive(0, 32'h0, 1, 5'b00000, 1, "R7 R6 forced inexact trap");
    drive(0, 32'h0, 0, 5'd0, 0, "R10 idle end");
    @(negedge clk);
    ld_en = 0; op_done = 0;
    repeat (2) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule